// File: doc/BRIEF.md
# CAN Nominal Bit Timing Generator

This block turns a fast oscillator clock into the nominal bit grid of a CAN node. It first divides the clock into time quanta. It then counts the quanta of each bit through four segments: a one-quantum sync segment, a propagation segment, a first phase segment and a second phase segment. The block produces a strobe at the start of every bit and a strobe at the sample point. Together with the sample-point strobe it gives the bit value it has captured. It can take a single sample or the majority of three samples spaced one quantum apart.

All timing comes from three packed 8-bit configuration words. Segment lengths are stored minus one. The quantum length is twice the prescaler field plus two. The second phase segment is either programmed or derived from the first. The block follows the receive line for synchronisation. While the bus is idle, a recessive-to-dominant transition restarts the bit (hard synchronisation). During traffic, the same transition stretches phase 1 or cuts phase 2 by the measured error, limited by the jump width. Frame decoding, stuffing and error handling belong to the logic that consumes the strobes.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2*(P+1) clock cycles, where P is `cfg_rate[5:0]`.
- R2: A bit lasts 1 + PROP + PH1 + PH2 quanta, with PROP = `cfg_seg[2:0]`+1 and PH1 = `cfg_seg[5:3]`+1. For example, a rate word of 0x01 with PROP 2, PH1 2 and PH2 3 gives 32 cycles per bit, and a rate word of 0x04 with PROP 3, PH1 8 and PH2 8 gives 200 cycles.
- R3: When `cfg_seg[7]` is 1, PH2 = `cfg_tail[2:0]`+1. When it is 0, PH2 = max(PH1, 2) and `cfg_tail` has no effect.
- R4: `sample_stb` is a one-cycle pulse that comes (PROP+PH1) quanta after `bit_start`, so the sample point lies at the end of phase 1. The two strobes are never high in the same cycle.
- R5: In single-sample mode (`cfg_seg[6]`=0), `rx_bit` takes the value of `rx_in` seen at the quantum tick that ends phase 1. `rx_bit` changes only in cycles where `sample_stb` is high.
- R6: In triple-sample mode (`cfg_seg[6]`=1), `rx_bit` is the majority of the `rx_in` values seen at the ticks that end the sample quantum and the two quanta before it.
- R7: The receive line is examined at every quantum tick. A falling edge means 1 at the previous tick and 0 at this one. With `bus_idle` high, a falling edge makes the quantum that just ended the sync segment, and `bit_start` pulses in the next cycle.
- R8: With `bus_idle` low, a falling edge seen at the end of quantum q, where 1 <= q <= PROP+PH1, lengthens phase 1 by min(q, SJW) quanta. SJW = `cfg_rate[7:6]`+1. The sample point and the end of the bit both move by that amount.
- R9: With `bus_idle` low, a falling edge seen at the end of quantum q inside phase 2 shortens the bit by min(NBT-q, SJW) quanta, where NBT is the nominal quantum count. If the shortening equals the error, the edge quantum becomes the next sync segment.
- R10: Reset is synchronous and active high. During and after reset, `bit_start` and `sample_stb` are 0 and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rate | input | 8 | [7:6] jump width minus one, [5:0] prescaler field |
| cfg_seg | input | 8 | [7] programmed phase 2, [6] triple sample, [5:3] phase 1 minus one, [2:0] propagation minus one |
| cfg_tail | input | 8 | [2:0] phase 2 minus one |
| rx_in | input | 1 | Receive line, 1 = recessive |
| bus_idle | input | 1 | High while no frame is in progress (enables hard sync) |
| bit_start | output | 1 | One-cycle pulse at the start of each bit |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| rx_bit | output | 1 | Sampled bit value, valid with `sample_stb` |

## Verification
Suppose the quantum counter or the stored phase-1 extension were wrong. The bit period and the bit-start-to-sample distance would then shift by whole quanta, and the error would be visible at the very next pair of strobes, within one bit. A wrong sample history would give the wrong `rx_bit` at the first sample after a glitch that covers only one of the three vote points. A resynchronisation step applied to the wrong branch, or left unclamped, shows up as a shortened or lengthened period in the bit that contains the edge.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
package cbt_pkg;
    localparam int REG_W = 8;
    localparam int PRE_W = 8;
    localparam int SEG_W = 4;
    localparam int Q_W   = 6;

    typedef struct packed {
        logic [2:0]       sjw;
        logic [SEG_W-1:0] prop;
        logic [SEG_W-1:0] ph1;
        logic [SEG_W-1:0] ph2;
    } seg_cfg_t;

    typedef struct packed {
        logic [5:0] brp;
        logic       triple;
        seg_cfg_t   seg;
    } bit_cfg_t;

    typedef struct packed {
        logic [Q_W-1:0] q;
        logic [Q_W-1:0] ext;
        logic           resynced;
    } seg_state_t;

    function automatic bit_cfg_t decode_cfg(input logic [REG_W-1:0] rate,
                                            input logic [REG_W-1:0] seg,
                                            input logic [REG_W-1:0] tail);
        bit_cfg_t c;
        c.brp      = rate[5:0];
        c.seg.sjw  = {1'b0, rate[7:6]} + 3'd1;
        c.seg.prop = {1'b0, seg[2:0]} + 4'd1;
        c.seg.ph1  = {1'b0, seg[5:3]} + 4'd1;
        if (seg[7])
            c.seg.ph2 = {1'b0, tail[2:0]} + 4'd1;
        else
            c.seg.ph2 = (c.seg.ph1 > 4'd2) ? c.seg.ph1 : 4'd2;
        c.triple = seg[6];
        return c;
    endfunction

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic [Q_W-1:0] umin(input logic [Q_W-1:0] a, input logic [Q_W-1:0] b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/cbt_prescaler.sv
`timescale 1ns/1ps
module cbt_prescaler #(
    parameter int CNT_W = cbt_pkg::PRE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] brp,
    output logic       tq_tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // quantum length 2*(brp+1) -> terminal count 2*brp+1
    assign limit   = CNT_W'({brp, 1'b1});
    assign tq_tick = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (tq_tick) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cbt_sampler.sv
`timescale 1ns/1ps
module cbt_sampler
    import cbt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tq_tick,
    input  logic rx_in,
    input  logic sample_now,
    input  logic triple,
    output logic prev_q,
    output logic rx_bit
);
    // hist[0]: line at previous tick, hist[1]: two ticks back
    logic [1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist   <= 2'b11;
            rx_bit <= 1'b1;
        end else begin
            if (tq_tick)
                hist <= {hist[0], rx_in};
            if (sample_now)
                rx_bit <= triple ? majority3(hist[1], hist[0], rx_in) : rx_in;
        end
    end

    assign prev_q = hist[0];
endmodule

// File: rtl/cbt_segmenter.sv
`timescale 1ns/1ps
module cbt_segmenter
    import cbt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tq_tick,
    input  seg_cfg_t cfg,
    input  logic     rx_in,
    input  logic     prev_q,
    input  logic     bus_idle,
    output logic     sample_now,
    output logic     bit_start,
    output logic     sample_stb
);
    seg_state_t     st, st_n;
    logic           bs_n, fall, hard;
    logic [Q_W-1:0] sp, last, nbt, sp_eff, last_eff, err, step, tgt;

    always_comb begin
        sp       = Q_W'(cfg.prop) + Q_W'(cfg.ph1);
        last     = sp + Q_W'(cfg.ph2);
        nbt      = last + 1'b1;
        sp_eff   = sp + st.ext;
        last_eff = last + st.ext;
        fall     = tq_tick && prev_q && !rx_in;
        hard     = fall && bus_idle;
        sample_now = tq_tick && (st.q == sp_eff) && !hard;

        // phase error in quanta: late before the sample point, early after it
        err  = (st.q <= sp) ? st.q : (nbt - st.q);
        step = umin(err, Q_W'(cfg.sjw));
        tgt  = st.q + 1'b1 + step;
        if (tgt >= nbt) tgt = tgt - nbt;

        st_n = st;
        bs_n = 1'b0;
        if (tq_tick) begin
            if (hard) begin
                st_n.q = Q_W'(1); st_n.ext = '0; st_n.resynced = 1'b1; bs_n = 1'b1;
            end else if (fall && !st.resynced && st.q != '0) begin
                if (st.q <= sp) begin
                    st_n.q = st.q + 1'b1; st_n.ext = step; st_n.resynced = 1'b1;
                end else if (tgt == Q_W'(1)) begin
                    st_n.q = Q_W'(1); st_n.ext = '0; st_n.resynced = 1'b0; bs_n = 1'b1;
                end else if (tgt == '0) begin
                    st_n.q = '0; st_n.ext = '0; st_n.resynced = 1'b0;
                end else begin
                    st_n.q = tgt; st_n.resynced = 1'b1;
                end
            end else if (st.q >= last_eff) begin
                st_n.q = '0; st_n.ext = '0; st_n.resynced = 1'b0;
            end else if (st.q == '0) begin
                st_n.q = Q_W'(1); bs_n = 1'b1;
            end else begin
                st_n.q = st.q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= '0;
            bit_start  <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            st         <= st_n;
            bit_start  <= bs_n;
            sample_stb <= sample_now;
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer
    import cbt_pkg::*;
#(
    parameter int CNT_W = PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] cfg_rate,
    input  logic [REG_W-1:0] cfg_seg,
    input  logic [REG_W-1:0] cfg_tail,
    input  logic             rx_in,
    input  logic             bus_idle,
    output logic             bit_start,
    output logic             sample_stb,
    output logic             rx_bit
);
    bit_cfg_t cfg;
    logic     tq_tick;
    logic     sample_now;
    logic     prev_q;

    assign cfg = decode_cfg(cfg_rate, cfg_seg, cfg_tail);

    cbt_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .brp     (cfg.brp),
        .tq_tick (tq_tick)
    );

    cbt_segmenter u_seg (
        .clk        (clk),
        .rst        (rst),
        .tq_tick    (tq_tick),
        .cfg        (cfg.seg),
        .rx_in      (rx_in),
        .prev_q     (prev_q),
        .bus_idle   (bus_idle),
        .sample_now (sample_now),
        .bit_start  (bit_start),
        .sample_stb (sample_stb)
    );

    cbt_sampler u_smp (
        .clk        (clk),
        .rst        (rst),
        .tq_tick    (tq_tick),
        .rx_in      (rx_in),
        .sample_now (sample_now),
        .triple     (cfg.triple),
        .prev_q     (prev_q),
        .rx_bit     (rx_bit)
    );
endmodule

// File: rtl/cbt_checker.sv
`timescale 1ns/1ps
module cbt_checker (
    input logic clk,
    input logic rst,
    input logic tq_tick,
    input logic bit_start,
    input logic sample_stb,
    input logic rx_bit
);
    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(bit_start && sample_stb));

    assert_sample_single_R4: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

    assert_sample_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> $past(tq_tick));

    assert_start_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        bit_start |-> $past(tq_tick));

    assert_start_single_R7: assert property (@(posedge clk) disable iff (rst)
        bit_start |=> !bit_start);

    assert_bit_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |-> $stable(rx_bit));
endmodule

bind can_bit_timer cbt_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tq_tick    (tq_tick),
    .bit_start  (bit_start),
    .sample_stb (sample_stb),
    .rx_bit     (rx_bit)
);

// File: tb/tb_can_bit_timer.sv
`timescale 1ns/1ps
module tb_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_rate = 8'h00;
    logic [7:0] cfg_seg  = 8'h00;
    logic [7:0] cfg_tail = 8'h00;
    logic       rx_in    = 1'b1;
    logic       bus_idle = 1'b0;
    logic       bit_start, sample_stb, rx_bit;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_bit_timer dut (
        .clk(clk), .rst(rst), .cfg_rate(cfg_rate), .cfg_seg(cfg_seg),
        .cfg_tail(cfg_tail), .rx_in(rx_in), .bus_idle(bus_idle),
        .bit_start(bit_start), .sample_stb(sample_stb), .rx_bit(rx_bit)
    );

    // {rate, seg, tail, cycles per bit, cycles bit_start -> sample_stb}
    localparam logic [47:0] VECS [5] = '{
        {8'h01, 8'h89, 8'h02, 12'd32,  12'd16},
        {8'h04, 8'hBA, 8'h07, 12'd200, 12'd110},
        {8'h00, 8'h00, 8'h05, 12'd10,  12'd4},
        {8'h02, 8'h22, 8'h07, 12'd84,  12'd48},
        {8'h00, 8'h91, 8'h00, 12'd14,  12'd10}
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart(input logic [7:0] r, input logic [7:0] s, input logic [7:0] t,
                           input logic rx0, input logic idle);
        @(negedge clk);
        rst = 1'b1; cfg_rate = r; cfg_seg = s; cfg_tail = t; rx_in = rx0; bus_idle = idle;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_bs(output int t);
        do @(negedge clk); while (!bit_start);
        t = cyc;
    endtask

    task automatic next_ss(input int t0, output int d);
        do @(negedge clk); while (!sample_stb);
        d = cyc - t0;
    endtask

    task automatic next_bs(input int t0, output int d);
        do @(negedge clk); while (!bit_start);
        d = cyc - t0;
    endtask

    // P=2 cycles per quantum, PROP 2, PH1 3, PH2 3: sample at quantum 5, 9 quanta
    task automatic edge_case(input string req, input logic [7:0] r, input logic idle,
                             input int k, input int exp_ss, input int exp_bs);
        int t0, d;
        restart(r, 8'h91, 8'h02, 1'b1, idle);
        wait_bs(t0);
        wait_bs(t0);
        if (k <= 5) begin
            repeat ((k - 1) * 2) @(posedge clk);
            @(negedge clk);
            rx_in = 1'b0;
            if (exp_ss > 0) begin
                next_ss(t0, d);
                check(req, d, exp_ss);
            end
        end else begin
            next_ss(t0, d);
            check(req, d, exp_ss);
            repeat ((k - 1) * 2 - 10) @(posedge clk);
            @(negedge clk);
            rx_in = 1'b0;
        end
        next_bs(t0, d);
        check(req, d, exp_bs);
    endtask

    // line low, driven high for quantum 5 only (or quanta 4 and 5)
    task automatic vote_case(input string req, input logic [7:0] s, input logic wide,
                             input logic exp);
        int t0;
        restart(8'h00, s, 8'h02, 1'b0, 1'b0);
        wait_bs(t0);
        wait_bs(t0);
        repeat (wide ? 6 : 8) @(posedge clk);
        @(negedge clk);
        rx_in = 1'b1;
        repeat (wide ? 4 : 2) @(posedge clk);
        @(negedge clk);
        check({req, " strobe"}, int'(sample_stb), 1);
        check(req, int'(rx_bit), int'(exp));
        rx_in = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int t0, d;
        // R10 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 bit_start", int'(bit_start), 0);
        check("R10 sample_stb", int'(sample_stb), 0);
        check("R10 rx_bit", int'(rx_bit), 1);

        // R1 R2 R3 R4: period and sample offset per configuration
        for (int i = 0; i < 5; i++) begin
            restart(VECS[i][47:40], VECS[i][39:32], VECS[i][31:24], 1'b1, 1'b0);
            wait_bs(t0);
            next_ss(t0, d);
            check($sformatf("R4 sample offset vec%0d", i), d, int'(VECS[i][11:0]));
            check($sformatf("R5 recessive bit vec%0d", i), int'(rx_bit), 1);
            next_bs(t0, d);
            check($sformatf("R1 R2 R3 bit period vec%0d", i), d, int'(VECS[i][23:12]));
        end

        // R5 R6 sampling modes
        vote_case("R5 single sample glitch", 8'h91, 1'b0, 1'b1);
        vote_case("R6 triple vote one of three", 8'hD1, 1'b0, 1'b0);
        vote_case("R6 triple vote two of three", 8'hD1, 1'b1, 1'b1);

        // R8 lengthening, limited by jump width
        edge_case("R8 sjw2 edge q2", 8'h40, 1'b0, 2, 14, 22);
        edge_case("R8 sjw1 clamp edge q2", 8'h00, 1'b0, 2, 12, 20);
        edge_case("R8 sjw4 edge q3", 8'hC0, 1'b0, 3, 16, 24);
        // R9 shortening
        edge_case("R9 sjw2 edge q7", 8'h40, 1'b0, 7, 10, 14);
        edge_case("R9 sjw1 clamp edge q7", 8'h00, 1'b0, 7, 10, 16);
        // R7 hard synchronisation while idle
        edge_case("R7 hard sync edge q4", 8'h00, 1'b1, 4, 0, 8);
        edge_case("R7 hard sync edge q7", 8'h00, 1'b1, 7, 10, 14);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule